// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This block sits beside a single-precision arithmetic datapath and decides, for each issued operation, whether the final result word must come from NaN propagation rather than from the arithmetic itself. It handles the two-source operations (add, subtract, multiply, divide) and the fused multiply-add and multiply-subtract, where the destination register's previous contents act as a third operand, called the accumulator.

Each operand is sorted into signaling NaN, quiet NaN or number. The selection follows a fixed priority. For fused operations the accumulator is examined first. Between the two sources, the second source wins ties. When the datapath raises an invalid-operation condition and no operand is a NaN, the result is the constant `32'h7FFF_FFFF`. Comparison and other operation classes never receive an override.

Inputs are sampled on an input strobe. The result, the override flag and the invalid flag appear one clock later, together with a single-cycle valid pulse.

Top module: `fp_nan_select`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for exactly the next cycle and carries results for those inputs. A synchronous reset clears `out_valid`, `result`, `override` and `invalid` to 0.
- R2: A word is a NaN when bits [30:23] are all ones and bits [22:0] are nonzero. It is quiet when bit 22 is 1 and signaling when bit 22 is 0. Infinities and zeros are numbers.
- R3: Quieting a NaN sets bit 22 and leaves every other bit of the word unchanged.
- R4: For the two-source rules, a signaling NaN is preferred over a quiet NaN. If both sources are signaling, the result is `src2` quieted.
- R5: For the two-source rules, if both sources are quiet NaNs the result is `src2` unchanged. If exactly one source is a NaN, that NaN is returned, quieted if it was signaling.
- R6: If no participating operand is a NaN and `dp_invalid` is high for an arithmetic class, the result is `32'h7FFF_FFFF` with `override` high.
- R7: For fused classes (`op_class` 4 = multiply-add, 5 = multiply-subtract), a quiet NaN accumulator is returned unchanged and a signaling NaN accumulator is returned quieted, whatever the sources hold.
- R8: For fused classes with a numeric accumulator, the two-source rules R4 and R5 apply to `src1` and `src2`. For classes 0 to 3 (add, subtract, multiply, divide) the accumulator is ignored.
- R9: `invalid` is high when `dp_invalid` is high or when a participating operand is a signaling NaN. Sources do not participate when a fused accumulator is a NaN.
- R10: For an arithmetic class with no NaN operand and `dp_invalid` low, `override` is 0 and `result` is 0.
- R11: For `op_class` 6 (compare) and 7 (other), `override` is 0 and `result` is 0 even when operands are NaNs. `invalid` equals `dp_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| op_class | input | 3 | 0 add, 1 sub, 2 mul, 3 div, 4 fused add, 5 fused sub, 6 compare, 7 other |
| src1 | input | 32 | First source word |
| src2 | input | 32 | Second source word |
| acc | input | 32 | Accumulator (previous destination value) |
| dp_invalid | input | 1 | Invalid-operation indication from the datapath |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Selected result word |
| override | output | 1 | Result replaces the datapath result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
A wrong priority or classification shows up as a wrong `result` word or `override` flag on the very next `out_valid` pulse. The stimulus therefore pits operand kinds against each other: signaling against quiet, source against source, and accumulator against sources, with boundary words such as infinity and the smallest signaling payload. A bad quieting mask corrupts other bits of the word in that same cycle, so the full word is compared. A stuck or stretched valid register appears one cycle after the strobe.

// File: rtl/fp_nan_select.sv
module fp_nan_select #(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23,
  parameter logic [1+EXP_W+FRAC_W-1:0] INV_WORD = {1'b0, {(EXP_W+FRAC_W){1'b1}}}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [2:0]                op_class,
  input  logic [1+EXP_W+FRAC_W-1:0] src1,
  input  logic [1+EXP_W+FRAC_W-1:0] src2,
  input  logic [1+EXP_W+FRAC_W-1:0] acc,
  input  logic                      dp_invalid,
  output logic                      out_valid,
  output logic [1+EXP_W+FRAC_W-1:0] result,
  output logic                      override,
  output logic                      invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam int QB = FRAC_W - 1;
  localparam logic [W-1:0] QMASK = W'(1) << QB;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
  endfunction

  wire s1_q = is_nan(src1) &  src1[QB];
  wire s1_s = is_nan(src1) & ~src1[QB];
  wire s2_q = is_nan(src2) &  src2[QB];
  wire s2_s = is_nan(src2) & ~src2[QB];
  wire ac_q = is_nan(acc)  &  acc[QB];
  wire ac_s = is_nan(acc)  & ~acc[QB];
  wire arith = op_class <= 3'd5;
  wire fused = (op_class == 3'd4) || (op_class == 3'd5);

  logic [W-1:0] n_res;
  logic n_ovr, n_inv;

  always_comb begin
    n_res = '0;
    n_ovr = 1'b0;
    n_inv = dp_invalid;
    if (arith) begin
      n_ovr = 1'b1;
      if (fused && ac_q)      n_res = acc;
      else if (fused && ac_s) begin n_res = acc | QMASK; n_inv = 1'b1; end
      else if (s2_s)          begin n_res = src2 | QMASK; n_inv = 1'b1; end
      else if (s1_s)          begin n_res = src1 | QMASK; n_inv = 1'b1; end
      else if (s2_q)          n_res = src2;
      else if (s1_q)          n_res = src1;
      else if (dp_invalid)    n_res = INV_WORD;
      else                    n_ovr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      override  <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= n_res;
        override <= n_ovr;
        invalid  <= n_inv;
      end
    end
  end

  p_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_quiet_out_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && override) |-> (is_nan(result) && result[QB]));
  p_zero_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !override) |-> (result == '0));
  p_acc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fused && ac_q) |=> (result == $past(acc)));
  p_no_cmp_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !arith) |=> (!override && invalid == $past(dp_invalid)));
  p_dp_inv_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dp_invalid) |=> invalid);
endmodule

// File: tb/fp_nan_select_bench.sv
module fp_nan_select_bench;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, dp_invalid = 1'b0;
  logic [2:0] op_class = '0;
  logic [31:0] src1 = '0, src2 = '0, acc = '0;
  logic out_valid, override, invalid;
  logic [31:0] result;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fp_nan_select u_fp_nan_select (.clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .src1(src1), .src2(src2), .acc(acc), .dp_invalid(dp_invalid), .out_valid(out_valid),
    .result(result), .override(override), .invalid(invalid));

  function automatic int kind(input logic [31:0] x);
    if (x[30:23] != 8'hFF || x[22:0] == 0) return 0;
    return x[22] ? 1 : 2;
  endfunction

  function automatic void model(input logic [2:0] oc, input logic [31:0] a, b, c, input logic dv,
      output logic [31:0] r, output logic ov, output logic iv, output string tag);
    int ka = kind(a), kb = kind(b), kc = kind(c);
    r = 32'h0; ov = 0; iv = dv; tag = "R10";
    if (oc > 3'd5) begin tag = "R11"; return; end
    if ((oc == 3'd4 || oc == 3'd5) && kc != 0) begin
      ov = 1; tag = "R7";
      r = (kc == 2) ? {c[31:23], 1'b1, c[21:0]} : c;
      iv = dv | (kc == 2);
      return;
    end
    iv = dv | (ka == 2) | (kb == 2);
    if (ka == 0 && kb == 0) begin
      if (dv) begin r = 32'h7FFF_FFFF; ov = 1; tag = "R6"; end
      return;
    end
    ov = 1;
    if (kb == 2)      begin r = {b[31:23], 1'b1, b[21:0]}; tag = "R4"; end
    else if (ka == 2) begin r = {a[31:23], 1'b1, a[21:0]}; tag = "R4"; end
    else if (kb == 1) begin r = b; tag = "R5"; end
    else              begin r = a; tag = "R5"; end
    if (oc >= 3'd4) tag = "R8";
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] oc, input logic [31:0] a, b, c, input logic dv);
    logic [31:0] er; logic eo, ei; string tg;
    model(oc, a, b, c, dv, er, eo, ei, tg);
    @(negedge clk);
    op_class = oc; src1 = a; src2 = b; acc = c; dp_invalid = dv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid", {31'b0, out_valid}, 32'd1);
    check({tg, " result"}, result, er);
    check({tg, " override"}, {31'b0, override}, {31'b0, eo});
    check({"R9 invalid/", tg}, {31'b0, invalid}, {31'b0, ei});
  endtask

  function automatic logic [31:0] gen();
    logic [31:0] x = $urandom;
    case ($urandom_range(4, 0))
      0: x[30:23] = 8'h7F;
      1: begin x[30:23] = 8'hFF; x[22] = 1'b1; end
      2: begin x[30:23] = 8'hFF; x[22] = 1'b0; if (x[21:0] == 0) x[0] = 1'b1; end
      3: begin x[30:23] = 8'hFF; x[22:0] = '0; end
      default: x[30:0] = '0;
    endcase
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    check("R1 reset flags", {30'b0, override, invalid}, 32'd0);
    rst = 1'b0;
    // R2 R3 R4: sNaN vs qNaN, both sNaN, smallest payload
    issue(3'd0, 32'h7F80_0001, 32'hFFC0_0005, 32'h0, 1'b0);
    issue(3'd2, 32'h7F80_0001, 32'hFF80_0002, 32'h0, 1'b0);
    // R5: both quiet, single quiet, infinity is a number (R2)
    issue(3'd1, 32'h7FC0_1234, 32'hFFC0_0001, 32'h0, 1'b0);
    issue(3'd3, 32'h7F80_0000, 32'h7FC0_0009, 32'h0, 1'b0);
    // R6: invalid without NaN
    issue(3'd3, 32'h0, 32'h0, 32'h0, 1'b1);
    // R7: fused accumulator priority
    issue(3'd4, 32'h7F80_0001, 32'h7F80_0002, 32'hFFC0_0077, 1'b0);
    issue(3'd5, 32'h7FC0_0000, 32'h7F80_0002, 32'h7F80_0003, 1'b0);
    // R8: numeric accumulator, sources decide; accumulator ignored for add
    issue(3'd4, 32'h7F80_0010, 32'h3F80_0000, 32'h4000_0000, 1'b0);
    issue(3'd0, 32'h3F80_0000, 32'h4000_0000, 32'h7F80_0001, 1'b0);
    // R10: plain numbers
    issue(3'd1, 32'h3F80_0000, 32'h4000_0000, 32'h0, 1'b0);
    // R11: compare ignores NaNs
    issue(3'd6, 32'h7F80_0001, 32'h7FC0_0000, 32'h0, 1'b1);
    issue(3'd7, 32'h7F80_0001, 32'h7FC0_0000, 32'h0, 1'b0);
    @(negedge clk);
    check("R1 single pulse", {31'b0, out_valid}, 32'd0);
    for (int i = 0; i < 400; i++)
      issue(3'($urandom_range(7, 0)), gen(), gen(), gen(), 1'($urandom_range(1, 0)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule